// File: doc/BRIEF.md
# Program Sequencer With Call Stack

This block holds the program counter of a small 14-bit-instruction processor and chooses the next fetch address on every clock. It looks at the instruction word currently being executed, a skip request raised by the execute stage, and an interrupt request. It resolves sequential flow, skips, absolute jumps and calls, two kinds of return, and interrupt entry. Return addresses live in a small hardware stack.

One return form also delivers an 8-bit literal meant for the working register. The block presents it with a one-cycle load strobe. The other return form re-arms the global interrupt enable. Instruction memory and the ALU sit outside this block. The fetch address output drives the memory, and the execute stage consumes the working-register load port.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst` is high on a clock edge, the next state has `fetch_addr` = 0, `gie` = 0, `w_load` = 0, the stack pointer at slot 0 and every stack entry at 0.
- R2: A word whose bits [13:11] are 3'b101 is a jump. The next `fetch_addr` is bits [10:0] of the word, and the stack is left untouched.
- R3: A word whose bits [13:11] are 3'b100 is a call. It writes `fetch_addr`+1 onto the stack, and the next `fetch_addr` is bits [10:0] of the word.
- R4: A word whose bits [13:8] are 6'b110001 is a literal return. It pops the stack into `fetch_addr`. On the following cycle `w_load` is 1 for exactly one cycle and `w_data` equals bits [7:0] of the word. `w_data` then holds that value until the next literal return.
- R5: The exact word 14'h1009 is an interrupt return. It pops the stack into `fetch_addr` and sets `gie` to 1.
- R6: For any other word, the next `fetch_addr` is `fetch_addr`+1. If `skip_req` is high with such a word, the next `fetch_addr` is `fetch_addr`+2 instead.
- R7: When the word is a call, jump or return, `skip_req` has no effect on the next `fetch_addr`.
- R8: When `irq` and `gie` are both 1, the current word and any skip request are discarded. The current `fetch_addr` is pushed, the next `fetch_addr` is 0x008, and `gie` becomes 0. When `gie` is 0, `irq` is ignored.
- R9: The stack has 4 entries and wraps circularly. A fifth push overwrites the oldest entry. Each pop returns the entry just below the pointer, modulo 4, so a pop from an empty stack after reset returns 0.
- R10: `w_load` is 0 in every cycle that does not follow a literal return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 14 | Instruction word executing this cycle |
| skip_req | input | 1 | Execute stage asks to bypass the next instruction |
| irq | input | 1 | Interrupt request |
| fetch_addr | output | 11 | Current program counter / fetch address |
| w_load | output | 1 | One-cycle strobe: load `w_data` into the working register |
| w_data | output | 8 | Literal carried by the last literal return |
| gie | output | 1 | Global interrupt enable state |

## Verification
Every error in the pointer or in the stack entries reaches `fetch_addr` on the first return after the error. The bench therefore follows each call with a return and checks the address on the cycle right after. A stack that does not wrap would return a wrong address only on the fifth pop, so the bench pushes five times and pops five times. A wrong enable state shows up one cycle later, when an interrupt is either taken or ignored when it should not be. The bench pairs each masked and unmasked request with a check of `fetch_addr` and `gie`.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int INSTR_W = 14;
    localparam int ADDR_W  = 11;
    localparam int IMM_W   = 8;

    localparam logic [INSTR_W-1:0] RETI_WORD = 14'h1009;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_CALL,
        FLOW_JUMP,
        FLOW_RETW,
        FLOW_RETI
    } flow_e;

    typedef enum logic [2:0] {
        PCS_INC,
        PCS_SKIP,
        PCS_TARGET,
        PCS_STACK,
        PCS_VECTOR
    } pc_sel_e;

    typedef struct packed {
        pc_sel_e pc_sel;
        logic    push;
        logic    push_cur;   // push current PC instead of PC+1
        logic    pop;
        logic    gie_set;
        logic    gie_clr;
        logic    wload;
    } seq_ctl_t;

    function automatic flow_e classify(input logic [INSTR_W-1:0] iw);
        if (iw[13:11] == 3'b100)      return FLOW_CALL;
        else if (iw[13:11] == 3'b101) return FLOW_JUMP;
        else if (iw[13:8] == 6'b110001) return FLOW_RETW;
        else if (iw == RETI_WORD)     return FLOW_RETI;
        else                          return FLOW_SEQ;
    endfunction

endpackage

// File: rtl/pseq_decode.sv
module pseq_decode
    import pseq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               skip_req,
    input  logic               irq,
    input  logic               gie,
    output seq_ctl_t           ctl
);
    flow_e flow;

    always_comb begin
        flow = classify(instr);
        ctl  = '0;
        ctl.pc_sel = PCS_INC;
        if (irq && gie) begin
            ctl.pc_sel   = PCS_VECTOR;
            ctl.push     = 1'b1;
            ctl.push_cur = 1'b1;
            ctl.gie_clr  = 1'b1;
        end else begin
            unique case (flow)
                FLOW_CALL: begin
                    ctl.pc_sel = PCS_TARGET;
                    ctl.push   = 1'b1;
                end
                FLOW_JUMP: ctl.pc_sel = PCS_TARGET;
                FLOW_RETW: begin
                    ctl.pc_sel = PCS_STACK;
                    ctl.pop    = 1'b1;
                    ctl.wload  = 1'b1;
                end
                FLOW_RETI: begin
                    ctl.pc_sel  = PCS_STACK;
                    ctl.pop     = 1'b1;
                    ctl.gie_set = 1'b1;
                end
                default: ctl.pc_sel = skip_req ? PCS_SKIP : PCS_INC;
            endcase
        end
    end
endmodule

// File: rtl/pseq_stack.sv
module pseq_stack #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data
);
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_below;

    // circular index of the most recent entry
    always_comb begin
        if (sp == '0) sp_below = SP_W'(DEPTH - 1);
        else          sp_below = sp - 1'b1;
    end

    assign top_data = mem[sp_below];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= push_data;
            sp      <= (sp == SP_W'(DEPTH - 1)) ? '0 : sp + 1'b1;
        end else if (pop) begin
            sp <= sp_below;
        end
    end
endmodule

// File: rtl/pseq_pc.sv
module pseq_pc
    import pseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VECTOR = 11'h008
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_sel_e           pc_sel,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_inc
);
    logic [ADDR_W-1:0] pc_next;

    assign pc_inc = pc + ADDR_W'(1);

    always_comb begin
        unique case (pc_sel)
            PCS_SKIP:   pc_next = pc + ADDR_W'(2);
            PCS_TARGET: pc_next = target;
            PCS_STACK:  pc_next = stack_top;
            PCS_VECTOR: pc_next = VECTOR;
            default:    pc_next = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import pseq_pkg::*;
#(
    parameter int                STACK_DEPTH = 4,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR  = 11'h008
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               skip_req,
    input  logic               irq,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               w_load,
    output logic [IMM_W-1:0]   w_data,
    output logic               gie
);
    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] pc, pc_inc, stack_top, push_val;

    pseq_decode u_dec (
        .instr    (instr),
        .skip_req (skip_req),
        .irq      (irq),
        .gie      (gie),
        .ctl      (ctl)
    );

    assign push_val = ctl.push_cur ? pc : pc_inc;

    pseq_stack #(.WIDTH(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .pop       (ctl.pop),
        .push_data (push_val),
        .top_data  (stack_top)
    );

    pseq_pc #(.VECTOR(IRQ_VECTOR)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .pc_sel    (ctl.pc_sel),
        .target    (instr[ADDR_W-1:0]),
        .stack_top (stack_top),
        .pc        (pc),
        .pc_inc    (pc_inc)
    );

    assign fetch_addr = pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie    <= 1'b0;
            w_load <= 1'b0;
            w_data <= '0;
        end else begin
            if (ctl.gie_clr)      gie <= 1'b0;
            else if (ctl.gie_set) gie <= 1'b1;
            w_load <= ctl.wload;
            if (ctl.wload) w_data <= instr[IMM_W-1:0];
        end
    end
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
    input logic        clk,
    input logic        rst,
    input logic [13:0] instr,
    input logic        skip_req,
    input logic        irq,
    input logic [10:0] fetch_addr,
    input logic        w_load,
    input logic [7:0]  w_data,
    input logic        gie
);
    logic taken, is_call, is_jump, is_retw, is_reti, is_plain;
    assign taken    = irq && gie;
    assign is_call  = instr[13:11] == 3'b100;
    assign is_jump  = instr[13:11] == 3'b101;
    assign is_retw  = instr[13:8] == 6'b110001;
    assign is_reti  = instr == 14'h1009;
    assign is_plain = !is_call && !is_jump && !is_retw && !is_reti;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (fetch_addr == 11'd0 && !gie && !w_load));

    a_r2_jump_target: assert property (@(posedge clk) disable iff (rst)
        (is_jump && !taken) |=> fetch_addr == $past(instr[10:0]));

    a_r3_call_target: assert property (@(posedge clk) disable iff (rst)
        (is_call && !taken) |=> fetch_addr == $past(instr[10:0]));

    a_r4_literal_load: assert property (@(posedge clk) disable iff (rst)
        (is_retw && !taken) |=> (w_load && w_data == $past(instr[7:0])));

    a_r5_reti_enables: assert property (@(posedge clk) disable iff (rst)
        (is_reti && !taken) |=> gie);

    a_r6_skip_by_two: assert property (@(posedge clk) disable iff (rst)
        (is_plain && skip_req && !taken) |=> fetch_addr == $past(fetch_addr) + 11'd2);

    a_r8_irq_entry: assert property (@(posedge clk) disable iff (rst)
        taken |=> (fetch_addr == 11'h008 && !gie));

    a_r10_no_stray_load: assert property (@(posedge clk) disable iff (rst)
        !(is_retw && !taken) |=> !w_load);
endmodule

bind prog_sequencer pseq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr      (instr),
    .skip_req   (skip_req),
    .irq        (irq),
    .fetch_addr (fetch_addr),
    .w_load     (w_load),
    .w_data     (w_data),
    .gie        (gie)
);

// File: tb/prog_sequencer_tb.sv
module prog_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] instr = '0;
    logic        skip_req = 1'b0;
    logic        irq = 1'b0;
    logic [10:0] fetch_addr;
    logic        w_load;
    logic [7:0]  w_data;
    logic        gie;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [13:0] NOP  = 14'h0000;
    localparam logic [13:0] RETI = 14'h1009;

    always #10 clk = ~clk;  // 50 MHz

    prog_sequencer u_dut (
        .clk(clk), .rst(rst), .instr(instr), .skip_req(skip_req), .irq(irq),
        .fetch_addr(fetch_addr), .w_load(w_load), .w_data(w_data), .gie(gie)
    );

    function automatic logic [13:0] op_call(input logic [10:0] a);
        return {3'b100, a};
    endfunction
    function automatic logic [13:0] op_jump(input logic [10:0] a);
        return {3'b101, a};
    endfunction
    function automatic logic [13:0] op_retw(input logic [7:0] d);
        return {6'b110001, d};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [13:0] iw, input logic sk, input logic iq);
        instr = iw; skip_req = sk; irq = iq;
        @(posedge clk);
        @(negedge clk);
        instr = NOP; skip_req = 1'b0; irq = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", fetch_addr, 0);
        chk("R1 gie", gie, 0);
        chk("R1 w_load", w_load, 0);
    endtask

    task automatic t_empty_pop();
        step(op_retw(8'h33), 0, 0);
        chk("R9 empty pop pc", fetch_addr, 0);
        chk("R4 w_load", w_load, 1);
        chk("R4 w_data", w_data, 8'h33);
        step(NOP, 0, 0);
        chk("R10 w_load drops", w_load, 0);
        chk("R6 inc", fetch_addr, 1);
    endtask

    task automatic t_seq_skip();
        step(NOP, 0, 0);
        chk("R6 inc", fetch_addr, 2);
        step(NOP, 1, 0);
        chk("R6 skip", fetch_addr, 4);
    endtask

    task automatic t_jump();
        step(op_jump(11'h123), 0, 0);
        chk("R2 jump", fetch_addr, 11'h123);
        step(op_jump(11'h050), 1, 0);
        chk("R7 skip ignored on jump", fetch_addr, 11'h050);
    endtask

    task automatic t_call_ret();
        step(op_call(11'h400), 0, 0);
        chk("R3 call", fetch_addr, 11'h400);
        step(NOP, 0, 0);
        chk("R6 inc in sub", fetch_addr, 11'h401);
        step(op_retw(8'hA5), 1, 0);
        chk("R4 ret pc", fetch_addr, 11'h051);
        chk("R4 w_load", w_load, 1);
        chk("R4 w_data", w_data, 8'hA5);
        step(NOP, 0, 0);
        chk("R10 w_load one cycle", w_load, 0);
        chk("R4 w_data held", w_data, 8'hA5);
        chk("R6 inc", fetch_addr, 11'h052);
    endtask

    task automatic t_irq_masked();
        step(NOP, 0, 1);
        chk("R8 masked irq pc", fetch_addr, 11'h053);
        chk("R8 masked gie", gie, 0);
    endtask

    task automatic t_reti();
        step(op_call(11'h200), 0, 0);
        step(RETI, 0, 0);
        chk("R5 reti pc", fetch_addr, 11'h054);
        chk("R5 reti gie", gie, 1);
    endtask

    task automatic t_irq();
        step(op_call(11'h300), 0, 1);
        chk("R8 vector", fetch_addr, 11'h008);
        chk("R8 gie cleared", gie, 0);
        step(NOP, 0, 1);
        chk("R8 nested masked", fetch_addr, 11'h009);
        step(RETI, 0, 0);
        chk("R8 resume at interrupted pc", fetch_addr, 11'h054);
        chk("R5 gie", gie, 1);
        step(NOP, 1, 1);
        chk("R8 irq beats skip", fetch_addr, 11'h008);
        step(RETI, 0, 0);
        chk("R8 resume after skip", fetch_addr, 11'h054);
    endtask

    task automatic t_overflow();
        step(op_jump(11'h010), 0, 0);
        step(op_call(11'h100), 0, 0);
        step(op_call(11'h200), 0, 0);
        step(op_call(11'h300), 0, 0);
        step(op_call(11'h400), 0, 0);
        step(op_call(11'h500), 0, 0);
        chk("R3 deep call", fetch_addr, 11'h500);
        step(op_retw(8'h01), 0, 0);
        chk("R9 pop1", fetch_addr, 11'h401);
        step(op_retw(8'h02), 0, 0);
        chk("R9 pop2", fetch_addr, 11'h301);
        step(op_retw(8'h03), 0, 0);
        chk("R9 pop3", fetch_addr, 11'h201);
        step(op_retw(8'h04), 0, 0);
        chk("R9 pop4", fetch_addr, 11'h101);
        step(op_retw(8'h05), 0, 0);
        chk("R9 pop5 wraps", fetch_addr, 11'h401);
        chk("R4 last literal", w_data, 8'h05);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_empty_pop();
        t_seq_skip();
        t_jump();
        t_call_ret();
        t_irq_masked();
        t_reti();
        t_irq();
        t_overflow();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule